// File: doc/BRIEF.md
# USB Transfer Status Queue

This block sits between a USB serial interface engine and a microcontroller. When the engine has finished with a data buffer, it reports the endpoint number, the token direction and the buffer bank it used. The block keeps these records in a small queue, oldest first. It shows the oldest record to software as a single read-only status byte and raises a transfer-complete flag while at least one record is waiting.

Software reads the byte and then writes a one-cycle clear pulse to the flag. That pulse removes the head record. If more records are queued, the flag stays set and the next record appears in the byte. When the last record is removed, the flag drops. While the queue holds its full four records, the block tells the engine to answer any new endpoint request with a NAK.

Internally, a three-state controller (EMPTY, HOLD, FULL) decides each cycle whether a push and a pop are allowed. A ring of record slots stores the queue, and a formatter builds the status byte.

Top module: `usb_xfer_status_queue`

## Requirements
- R1: After reset the flag, the full indication, the NAK output and the status byte are all 0.
- R2: The status byte is {0, endpoint[3:0], dir, bank, 0}: bit 7 and bit 0 read 0, bits 6:3 hold the endpoint number, bit 2 is 1 for an IN token and 0 for OUT/SETUP, and bit 1 is 1 for the odd bank and 0 for the even bank.
- R3: A push into an empty queue sets the flag and presents that record from the cycle after the push edge.
- R4: Records are presented in push order, and the head does not change while no clear pulse arrives.
- R5: A clear pulse while the flag is set removes the head. If records remain, the flag stays set and the next record is shown from the following cycle. Otherwise the flag drops.
- R6: A clear pulse while the flag is low has no effect.
- R7: The full output is 1 exactly while four records are held. It drops in the cycle after a pop that has no push in the same cycle.
- R8: The NAK output is 1 in the same cycle that an endpoint request arrives while the queue is full, and 0 otherwise.
- R9: A push while full, with no clear pulse in the same cycle, is discarded and leaves the queue unchanged.
- R10: A push and a clear in the same cycle both take effect. The record count is unchanged and the byte shows the next record.
- R11: While the flag is low, the status byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Engine finished a buffer; record on push_* is valid |
| push_ep | input | 4 | Endpoint number of the record |
| push_dir | input | 1 | 1 = IN token, 0 = OUT/SETUP |
| push_bank | input | 1 | 1 = odd bank, 0 = even bank |
| ep_request | input | 1 | Engine sees a new endpoint request |
| ep_nak | output | 1 | Engine must NAK the request |
| flag_clr | input | 1 | One-cycle clear pulse for the flag |
| xfer_done | output | 1 | Transfer-complete flag |
| queue_full | output | 1 | Four records held |
| status_byte | output | 8 | Head record, formatted |

## Verification
The hardest cases to reach from the ports are a push and a clear in the same cycle while the queue is full, and a push while full that must be dropped. Both need the queue to be filled first and then to receive one exact pairing of pulses. A directed sequence fills the queue and then applies these pairings. After that, a seeded random phase biases pushes above clears so the queue keeps returning to full while clears interleave.

// File: rtl/usb_stat_pkg.sv
`timescale 1ns/1ps
package usb_stat_pkg;
    localparam int EP_W = 4;

    typedef struct packed {
        logic [EP_W-1:0] ep;
        logic            dir;
        logic            bank;
    } stat_rec_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FULL  = 2'd2
    } q_state_e;
endpackage

// File: rtl/usb_stat_ring.sv
`timescale 1ns/1ps
module usb_stat_ring
    import usb_stat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  stat_rec_t                     wr_rec,
    input  logic                          rd_en,
    output stat_rec_t                     head_rec,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    stat_rec_t        slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Advance a pointer, wrapping at the last slot for any depth
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_ptr == PTR_W'(g))) begin
                slot[g] <= wr_rec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_rec = slot[rd_ptr];
endmodule

// File: rtl/usb_stat_ctrl.sv
`timescale 1ns/1ps
module usb_stat_ctrl
    import usb_stat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_req,
    input  logic                          clr_req,
    input  logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          wr_en,
    output logic                          rd_en,
    output logic                          flag,
    output logic                          full
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] NEAR_TOP = CNT_W'(DEPTH - 1);

    q_state_e state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    // Accept decisions and next-state transitions
    always_comb begin
        rd_en    = 1'b0;
        wr_en    = 1'b0;
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                // clear while empty is ignored; a push makes one record
                wr_en = push_req;
                if (push_req) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                rd_en = clr_req;
                wr_en = push_req;
                if (push_req && !clr_req && count == NEAR_TOP)
                    state_nx = ST_FULL;
                else if (clr_req && !push_req && count == ONE)
                    state_nx = ST_EMPTY;
            end
            ST_FULL: begin
                // a push is taken only when a pop frees a slot in the same cycle
                rd_en = clr_req;
                wr_en = push_req && clr_req;
                if (clr_req && !push_req) state_nx = ST_HOLD;
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        flag = 1'b0;
        full = 1'b0;
        unique case (state)
            ST_EMPTY: ;
            ST_HOLD:  flag = 1'b1;
            ST_FULL: begin
                flag = 1'b1;
                full = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usb_stat_fmt.sv
`timescale 1ns/1ps
module usb_stat_fmt
    import usb_stat_pkg::*;
(
    input  stat_rec_t  rec,
    input  logic       valid,
    output logic [7:0] stat_byte
);
    always_comb begin
        stat_byte = 8'h00;
        if (valid) begin
            stat_byte[6:3] = rec.ep;
            stat_byte[2]   = rec.dir;
            stat_byte[1]   = rec.bank;
        end
    end
endmodule

// File: rtl/usb_xfer_status_queue.sv
`timescale 1ns/1ps
module usb_xfer_status_queue
    import usb_stat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  logic [3:0] push_ep,
    input  logic       push_dir,
    input  logic       push_bank,
    input  logic       ep_request,
    output logic       ep_nak,
    input  logic       flag_clr,
    output logic       xfer_done,
    output logic       queue_full,
    output logic [7:0] status_byte
);
    localparam int CNT_W = $clog2(DEPTH+1);

    stat_rec_t        in_rec;
    stat_rec_t        head_rec;
    logic [CNT_W-1:0] count;
    logic             wr_en;
    logic             rd_en;

    assign in_rec = '{ep: push_ep, dir: push_dir, bank: push_bank};

    usb_stat_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_valid),
        .clr_req  (flag_clr),
        .count    (count),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .flag     (xfer_done),
        .full     (queue_full)
    );

    usb_stat_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_rec   (in_rec),
        .rd_en    (rd_en),
        .head_rec (head_rec),
        .count    (count)
    );

    usb_stat_fmt u_fmt (
        .rec       (head_rec),
        .valid     (xfer_done),
        .stat_byte (status_byte)
    );

    assign ep_nak = ep_request && queue_full;
endmodule

// File: rtl/usb_stat_chk.sv
`timescale 1ns/1ps
module usb_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       push_valid,
    input logic [3:0] push_ep,
    input logic       push_dir,
    input logic       push_bank,
    input logic       ep_request,
    input logic       ep_nak,
    input logic       flag_clr,
    input logic       xfer_done,
    input logic       queue_full,
    input logic [7:0] status_byte
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[7] == 1'b0 && status_byte[0] == 1'b0); // R2
    AST_PUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_done && push_valid) |=> xfer_done &&
        status_byte == {1'b0, $past(push_ep), $past(push_dir), $past(push_bank), 1'b0}); // R3
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !flag_clr) |=> xfer_done && $stable(status_byte)); // R4
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_done && flag_clr && !push_valid) |=> !xfer_done); // R6
    AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        queue_full |-> xfer_done); // R7
    AST_NAK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ep_nak |-> queue_full); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_full && push_valid && !flag_clr) |=> queue_full && $stable(status_byte)); // R9
    AST_SWAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_full && push_valid && flag_clr) |=> queue_full); // R10
    AST_IDLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |-> status_byte == 8'h00); // R11
endmodule

bind usb_xfer_status_queue usb_stat_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_valid  (push_valid),
    .push_ep     (push_ep),
    .push_dir    (push_dir),
    .push_bank   (push_bank),
    .ep_request  (ep_request),
    .ep_nak      (ep_nak),
    .flag_clr    (flag_clr),
    .xfer_done   (xfer_done),
    .queue_full  (queue_full),
    .status_byte (status_byte)
);

// File: tb/tb_usb_xfer_status_queue.sv
`timescale 1ns/1ps
module tb_usb_xfer_status_queue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [3:0] push_ep = '0;
    logic       push_dir = 1'b0;
    logic       push_bank = 1'b0;
    logic       ep_request = 1'b0;
    logic       flag_clr = 1'b0;
    logic       ep_nak;
    logic       xfer_done;
    logic       queue_full;
    logic [7:0] status_byte;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] mq [4];
    int         mcount = 0;

    always #2.5 clk = ~clk;

    usb_xfer_status_queue dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ep(push_ep),
        .push_dir(push_dir), .push_bank(push_bank), .ep_request(ep_request),
        .ep_nak(ep_nak), .flag_clr(flag_clr), .xfer_done(xfer_done),
        .queue_full(queue_full), .status_byte(status_byte)
    );

    // Status byte per R2: {0, ep, dir, bank, 0}
    function automatic logic [7:0] fmt(input logic [3:0] ep, input logic d, input logic b);
        return {1'b0, ep, d, b, 1'b0};
    endfunction

    function automatic logic [7:0] exp_byte();
        return (mcount > 0) ? mq[0] : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, step model at posedge, compare at next negedge
    task automatic cyc(input bit p, input logic [3:0] ep, input bit d, input bit b,
                       input bit c, input bit r, input string tag);
        bit pop;
        bit acc;
        push_valid = p; push_ep = ep; push_dir = d; push_bank = b;
        flag_clr = c; ep_request = r;
        #1;
        if (r) chk("R8 nak", {7'd0, ep_nak}, {7'd0, mcount == 4});
        @(posedge clk);
        pop = c && (mcount > 0);
        acc = p && (mcount < 4 || pop);
        if (pop) begin
            for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
            mcount--;
        end
        if (acc) begin
            mq[mcount] = fmt(ep, d, b);
            mcount++;
        end
        @(negedge clk);
        push_valid = 1'b0; flag_clr = 1'b0; ep_request = 1'b0;
        chk({tag, " flag"}, {7'd0, xfer_done}, {7'd0, mcount > 0});
        chk({tag, " full R7"}, {7'd0, queue_full}, {7'd0, mcount == 4});
        chk({tag, " byte"}, status_byte, exp_byte());
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 flag", {7'd0, xfer_done}, 8'd0);
        chk("R1 full", {7'd0, queue_full}, 8'd0);
        chk("R1 nak", {7'd0, ep_nak}, 8'd0);
        chk("R1 byte", status_byte, 8'd0);

        // R6: clear while flag low is ignored; R11 byte stays 0
        cyc(0, 4'h0, 0, 0, 1, 0, "R6 R11");
        // R3 R2: push ep5 IN even -> 0x2C
        cyc(1, 4'h5, 1, 0, 0, 0, "R3");
        chk("R2 layout", status_byte, 8'h2C);
        // R4 fill with distinct records
        cyc(1, 4'hA, 0, 1, 0, 0, "R4");
        cyc(1, 4'hF, 1, 1, 0, 1, "R4 R8");
        cyc(1, 4'h0, 0, 0, 0, 1, "R7");
        chk("R7 full", {7'd0, queue_full}, 8'd1);
        // R8: request while full
        cyc(0, 4'h0, 0, 0, 0, 1, "R8");
        // R9: push while full dropped
        cyc(1, 4'h3, 1, 1, 0, 0, "R9");
        chk("R9 head kept", status_byte, 8'h2C);
        // R10: push and pop while full
        cyc(1, 4'h9, 0, 1, 1, 0, "R10");
        chk("R10 head", status_byte, fmt(4'hA, 0, 1));
        // R5: drain in order
        cyc(0, 4'h0, 0, 0, 1, 0, "R5");
        chk("R5 next", status_byte, fmt(4'hF, 1, 1));
        cyc(0, 4'h0, 0, 0, 1, 0, "R5");
        cyc(0, 4'h0, 0, 0, 1, 0, "R5");
        cyc(0, 4'h0, 0, 0, 1, 0, "R5 last");
        chk("R5 empty", {7'd0, xfer_done}, 8'd0);
        // R10 at one record: push and pop together
        cyc(1, 4'h7, 1, 0, 0, 0, "R3");
        cyc(1, 4'h2, 0, 1, 1, 0, "R10 single");
        chk("R10 single head", status_byte, fmt(4'h2, 0, 1));

        // Random mix, pushes biased above clears
        for (int n = 0; n < 600; n++) begin
            cyc(($urandom % 100) < 55, 4'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 100) < 40, ($urandom % 4) == 0, "R4 R10 rand");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule